// File: doc/BRIEF.md
# Status Indicator Pin With Reset-Time Strap

This block owns one shared pad that has two jobs. While the active-low reset is held, the pad is released. The block takes the pad level on each rising clock edge, and the last such level is kept as a strap bit. That bit tells the rest of the chip whether a serial configuration memory is fitted. Once reset ends, the pad shows one network status indicator. Its polarity is programmable and is active low by default.

The pad is modelled as a drive-enable signal and a drive-value signal, so the two driver types can be told apart. With active-low polarity the pad behaves as open drain: it pulls low while the indicator is on and is released while it is off. With active-high polarity it behaves as push-pull and drives both levels.

A select input can hand the pad to one of several alternate functions, such as a serial memory clock. Those functions then drive the pad directly. The status and polarity inputs are plain control pins and have no handshake. They are registered before they reach the pad, so changing them cannot make the pad glitch.

Top module: `status_pin_ctrl`

## Requirements
- R1: The strap output equals the pad input level seen at the last rising clock edge at which rst_n was low: 1 means memory present, 0 means absent.
- R2: After rst_n rises, the strap output keeps its value whatever pad_in does.
- R3: While rst_n is low, pad_oe is 0 for every value of sel and of the alternate inputs.
- R4: With sel = 0 and pol_high = 0 (active low, open drain), pad_oe equals the registered status and pad_out is 0.
- R5: With sel = 0 and pol_high = 1 (active high, push-pull), pad_oe is 1 and pad_out equals the registered status.
- R6: A change on status_in or pol_high reaches the pad only after the next rising clock edge.
- R7: With 1 <= sel <= NUM_ALT, pad_oe = alt_oe[sel-1] and pad_out = alt_out[sel-1] in the same cycle, without any register in between.
- R8: With sel > NUM_ALT, the pad is released: pad_oe = 0 and pad_out = 0.
- R9: In the LED function, the pad stays released until the first rising edge after rst_n rises. At that edge the registered status and polarity take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; also the strap sampling window |
| pad_in | input | 1 | Level seen at the pad |
| status_in | input | 1 | Indicator source, 1 = indicator on |
| pol_high | input | 1 | 0 = active low (open drain), 1 = active high (push-pull) |
| sel | input | SEL_W | Pad owner: 0 = LED, 1..NUM_ALT = alternate function, above that = released |
| alt_oe | input | NUM_ALT | Drive enables of the alternate functions |
| alt_out | input | NUM_ALT | Drive values of the alternate functions |
| pad_oe | output | 1 | Pad driver enable |
| pad_out | output | 1 | Pad driver value |
| strap_present | output | 1 | Latched strap bit, 1 = configuration memory present |

## Verification
The hardest case to reach from the ports is the strap latch. Only the final edge of the reset window may count, and later pad activity must leave the bit unchanged. The bench holds reset for several edges and drives a changing pad level, so that the last level differs from the earlier ones. It then releases reset half a cycle after that edge and toggles pad_in. It repeats this for both strap values. A second hard case is the register stage on status and polarity. Here the bench changes those inputs between edges and samples the pad before and after the next edge.

// File: rtl/led_strap_pkg.sv
package led_strap_pkg;

  typedef enum logic [1:0] {
    OWN_LED  = 2'd0,
    OWN_ALT  = 2'd1,
    OWN_NONE = 2'd2
  } pin_owner_e;

  typedef enum logic {
    POL_LOW  = 1'b0,
    POL_HIGH = 1'b1
  } led_pol_e;

  typedef struct packed {
    logic oe;
    logic val;
  } pad_drive_t;

endpackage

// File: rtl/strap_latch.sv
module strap_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic pad_in,
  output logic strap_q
);

  // Samples on every edge while reset is low, then holds.
  always_ff @(posedge clk) begin
    if (!rst_n) strap_q <= pad_in;
  end

  // R2
  strap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(strap_q));

endmodule

// File: rtl/led_driver.sv
module led_driver
  import led_strap_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       status_in,
  input  logic       pol_in,
  output pad_drive_t drv
);

  logic     status_q;
  led_pol_e pol_q;
  logic     en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= 1'b0;
      pol_q    <= POL_LOW;
      en_q     <= 1'b0;
    end else begin
      status_q <= status_in;
      pol_q    <= led_pol_e'(pol_in);
      en_q     <= 1'b1;
    end
  end

  always_comb begin
    drv = '0;
    if (en_q) begin
      if (pol_q == POL_HIGH) begin
        drv.oe  = 1'b1;
        drv.val = status_q;
      end else begin
        drv.oe  = status_q;
        drv.val = 1'b0;
      end
    end
  end

  // R4
  open_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(pol_in)) |-> (drv.oe == $past(status_in)) && !drv.val);

  // R5
  push_pull_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(pol_in)) |-> drv.oe && (drv.val == $past(status_in)));

  // R9
  release_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> !drv.oe);

endmodule

// File: rtl/pad_select.sv
module pad_select
  import led_strap_pkg::*;
#(
  parameter int NUM_ALT = 2,
  parameter int SEL_W   = $clog2(NUM_ALT + 2)
) (
  input  logic [SEL_W-1:0]   sel,
  input  pad_drive_t         led_drv,
  input  logic [NUM_ALT-1:0] alt_oe,
  input  logic [NUM_ALT-1:0] alt_out,
  output pad_drive_t         mux_drv
);

  localparam int TAB_N = NUM_ALT + 1;

  pad_drive_t tab [TAB_N];
  pin_owner_e owner;

  assign tab[0] = led_drv;

  for (genvar g = 0; g < NUM_ALT; g++) begin : g_alt
    assign tab[g+1] = '{oe: alt_oe[g], val: alt_out[g]};
  end

  always_comb begin
    if (int'(sel) == 0)            owner = OWN_LED;
    else if (int'(sel) <= NUM_ALT) owner = OWN_ALT;
    else                           owner = OWN_NONE;
  end

  always_comb begin
    mux_drv = '0;
    for (int i = 0; i < TAB_N; i++) begin
      if (owner != OWN_NONE && int'(sel) == i) mux_drv = tab[i];
    end
  end

  // R8
  always_comb begin
    if (owner == OWN_NONE) begin
      released_chk: assert (!mux_drv.oe && !mux_drv.val);
    end
  end

endmodule

// File: rtl/status_pin_ctrl.sv
module status_pin_ctrl
  import led_strap_pkg::*;
#(
  parameter int NUM_ALT = 2,
  parameter int SEL_W   = $clog2(NUM_ALT + 2)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pad_in,
  input  logic               status_in,
  input  logic               pol_high,
  input  logic [SEL_W-1:0]   sel,
  input  logic [NUM_ALT-1:0] alt_oe,
  input  logic [NUM_ALT-1:0] alt_out,
  output logic               pad_oe,
  output logic               pad_out,
  output logic               strap_present
);

  pad_drive_t led_drv;
  pad_drive_t mux_drv;

  strap_latch u_strap (
    .clk     (clk),
    .rst_n   (rst_n),
    .pad_in  (pad_in),
    .strap_q (strap_present)
  );

  led_driver u_led (
    .clk       (clk),
    .rst_n     (rst_n),
    .status_in (status_in),
    .pol_in    (pol_high),
    .drv       (led_drv)
  );

  pad_select #(.NUM_ALT(NUM_ALT), .SEL_W(SEL_W)) u_sel (
    .sel     (sel),
    .led_drv (led_drv),
    .alt_oe  (alt_oe),
    .alt_out (alt_out),
    .mux_drv (mux_drv)
  );

  // Pad is released for every owner during reset so the strap level is clean.
  assign pad_oe  = rst_n & mux_drv.oe;
  assign pad_out = rst_n & mux_drv.val;

endmodule

// File: tb/status_pin_ctrl_bench.sv
module status_pin_ctrl_bench;

  localparam int NUM_ALT = 2;
  localparam int SEL_W   = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pad_in = 1'b0;
  logic status_in = 1'b0;
  logic pol_high = 1'b0;
  logic [SEL_W-1:0] sel = '0;
  logic [NUM_ALT-1:0] alt_oe = '0;
  logic [NUM_ALT-1:0] alt_out = '0;
  logic pad_oe, pad_out, strap_present;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  status_pin_ctrl #(.NUM_ALT(NUM_ALT), .SEL_W(SEL_W)) u_status_pin_ctrl (
    .clk(clk), .rst_n(rst_n), .pad_in(pad_in), .status_in(status_in),
    .pol_high(pol_high), .sel(sel), .alt_oe(alt_oe), .alt_out(alt_out),
    .pad_oe(pad_oe), .pad_out(pad_out), .strap_present(strap_present)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic next_cycle();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    // R3: pad released during reset for every select
    alt_oe = '1;
    alt_out = '1;
    status_in = 1'b1;
    pol_high = 1'b1;
    for (int s = 0; s < 4; s++) begin
      sel = SEL_W'(s);
      next_cycle();
      check("R3 pad_oe in reset", int'(pad_oe), 0);
    end

    // R1, R2, R9, R5: strap sweep over both values
    for (int v = 0; v < 2; v++) begin
      rst_n = 1'b0;
      sel = '0;
      status_in = 1'b1;
      pol_high = 1'b1;
      for (int k = 0; k < 4; k++) begin
        pad_in = ((k % 2) == 0) ? ~v[0] : v[0];
        if (k == 3) pad_in = v[0];
        next_cycle();
      end
      pad_in = ~v[0];
      next_cycle();
      pad_in = v[0];
      next_cycle();
      // last edge in reset saw v; release now, between edges
      rst_n = 1'b1;
      pad_in = ~v[0];
      #1;
      check("R9 pad_oe before first edge", int'(pad_oe), 0);
      check("R1 strap value", int'(strap_present), v);
      for (int k = 0; k < 4; k++) begin
        pad_in = ~pad_in;
        next_cycle();
        check("R2 strap hold", int'(strap_present), v);
      end
      check("R5 pad_oe after release", int'(pad_oe), 1);
      check("R5 pad_out after release", int'(pad_out), 1);
    end

    // R4, R5, R7, R8: exhaustive sweep
    for (int s = 0; s < 4; s++) begin
      for (int p = 0; p < 2; p++) begin
        for (int st = 0; st < 2; st++) begin
          for (int ao = 0; ao < 4; ao++) begin
            for (int av = 0; av < 4; av++) begin
              int eoe, eout;
              sel = SEL_W'(s);
              pol_high = p[0];
              status_in = st[0];
              alt_oe = NUM_ALT'(ao);
              alt_out = NUM_ALT'(av);
              next_cycle();
              if (s == 0) begin
                eoe  = (p == 1) ? 1 : st;
                eout = (p == 1) ? st : 0;
                if (p == 1) begin
                  check("R5 push-pull oe", int'(pad_oe), eoe);
                  check("R5 push-pull out", int'(pad_out), eout);
                end else begin
                  check("R4 open-drain oe", int'(pad_oe), eoe);
                  check("R4 open-drain out", int'(pad_out), eout);
                end
              end else if (s <= NUM_ALT) begin
                eoe  = (ao >> (s - 1)) & 1;
                eout = (av >> (s - 1)) & 1;
                check("R7 alt oe", int'(pad_oe), eoe);
                check("R7 alt out", int'(pad_out), eout);
              end else begin
                check("R8 released oe", int'(pad_oe), 0);
                check("R8 released out", int'(pad_out), 0);
              end
            end
          end
        end
      end
    end

    // R7: alternate path has no register
    sel = 2'd1;
    alt_oe = 2'b00;
    alt_out = 2'b00;
    next_cycle();
    alt_oe = 2'b01;
    alt_out = 2'b01;
    #1;
    check("R7 same-cycle oe", int'(pad_oe), 1);
    check("R7 same-cycle out", int'(pad_out), 1);

    // R6: status and polarity changes wait for the edge
    sel = '0;
    pol_high = 1'b1;
    status_in = 1'b0;
    next_cycle();
    status_in = 1'b1;
    #1;
    check("R6 status before edge", int'(pad_out), 0);
    next_cycle();
    check("R6 status after edge", int'(pad_out), 1);
    pol_high = 1'b0;
    #1;
    check("R6 polarity before edge out", int'(pad_out), 1);
    next_cycle();
    check("R6 polarity after edge out", int'(pad_out), 0);
    check("R6 polarity after edge oe", int'(pad_oe), 1);

    // R3: reassert reset, pad released at once
    rst_n = 1'b0;
    #1;
    check("R3 pad_oe on reassert", int'(pad_oe), 0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule